// File: doc/BRIEF.md
# Nibble-Swap and Skip-If-Zero Execute Unit

This block is the execute stage of a small 8-bit accumulator machine. It carries out four instructions that each name one byte of an internal 32-entry data memory. Two of them exchange the byte's upper and lower halves, either back into memory or into the accumulator. The other two test the byte for zero, and one of those also copies the byte into the accumulator first.

Instructions arrive as a 2-bit opcode and a 5-bit address under a valid/ready handshake. They go into a one-entry prefetch slot, so the next instruction is already fetched while the current one executes. When a zero test succeeds, the instruction that follows in program order is thrown away and its slot becomes a dummy cycle. A taken skip therefore costs two cycles, and a test that does not skip costs one.

A test port writes and reads the data memory directly. The accumulator, an 8-bit status register that none of these instructions changes, a cycle counter and two one-cycle pulse outputs let the surrounding logic follow execution.

Top module: `nsz_exec_unit`

## Requirements
- R1: A synchronous active-low reset gives `acc_o`=0, `status_o`=0, `cyc_cnt_o`=0, an empty prefetch slot (`in_ready`=1) and no pulses on `retire_o`/`dummy_o`. Data memory contents survive reset.
- R2: Opcode 2'b00 writes the addressed byte back with bits [3:0] and [7:4] exchanged. The accumulator is unchanged.
- R3: Opcode 2'b01 loads the accumulator with memory bits [7:4] in acc[3:0] and memory bits [3:0] in acc[7:4]. Memory is unchanged.
- R4: Opcode 2'b10 with an addressed byte of zero discards the next instruction in program order, which takes a dummy cycle. The skip and the dummy together take two counted cycles. Memory and accumulator are unchanged.
- R5: Opcode 2'b10 with a nonzero byte causes no dummy cycle. It takes one counted cycle, and the next instruction executes normally.
- R6: Opcode 2'b11 always copies the addressed byte into the accumulator, then applies the R4/R5 zero-skip rule to that byte.
- R7: A dummy cycle writes neither memory nor the accumulator. `dummy_o` is high for exactly one cycle per discarded instruction.
- R8: A skip instruction that is itself discarded never causes a further skip.
- R9: No instruction changes `status_o` after reset.
- R10: `cyc_cnt_o` increases by exactly one for each executed or dummy cycle. `retire_o` pulses once per executed instruction, and `retire_o` and `dummy_o` are never high together.
- R11: An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both high. While `tst_we` is high, execution stalls: the held slot is kept and `in_ready` is low if the slot is full.
- R12: `tst_we` writes `tst_wdata` to `tst_addr`, and `tst_rdata` combinationally returns the byte at `tst_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Prefetch slot can take an instruction |
| in_op | input | 2 | Opcode: 00 swap, 01 swap to accumulator, 10 skip if zero, 11 move then skip if zero |
| in_addr | input | 5 | Data memory address of the operand |
| tst_we | input | 1 | Test write strobe; stalls execution |
| tst_addr | input | 5 | Test port address |
| tst_wdata | input | 8 | Test write data |
| tst_rdata | output | 8 | Test read data at `tst_addr` |
| acc_o | output | 8 | Accumulator |
| status_o | output | 8 | Status register |
| cyc_cnt_o | output | 16 | Executed-plus-dummy cycle count |
| retire_o | output | 1 | Pulse: an instruction executed |
| dummy_o | output | 1 | Pulse: an instruction was discarded |

## Verification
The assertions assume that a test write never falls in the same cycle as an instruction execute. The design ensures this by stalling, so the stimulus may raise `tst_we` at any time. They also assume `in_op` and `in_addr` hold their values for as long as `in_valid` waits for `in_ready`, and the bench changes them only after acceptance. Random operands are drawn from a few addresses, and about a third of them are loaded with zero, so taken skips, back-to-back skips and squashed skips all occur regularly.

// File: rtl/nsz_pkg.sv
// Package: shared opcode type for the nibble-swap / skip-if-zero execute unit.
// Assumes a 2-bit opcode field; the encodings below are decoded by nsz_alu.
package nsz_pkg;

    typedef enum logic [1:0] {
        OP_SWAP  = 2'b00,   // exchange nibbles, write back to memory
        OP_SWAPA = 2'b01,   // exchange nibbles into accumulator
        OP_SKZ   = 2'b10,   // skip next instruction if byte is zero
        OP_MVSKZ = 2'b11    // copy byte to accumulator, skip if zero
    } nsz_op_e;

endpackage

// File: rtl/nsz_regfile.sv
// Module: nsz_regfile
// Register-file data memory with one execute read/write port and one test
// port. Both reads are combinational. Writes happen on the clock edge.
// Assumes the execute write and the test write never happen in the same
// cycle; the top stalls execution while the test port writes.
module nsz_regfile #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ex_addr,
    output logic [DATA_W-1:0] ex_rdata,
    input  logic              ex_we,
    input  logic [DATA_W-1:0] ex_wdata,
    input  logic [AW-1:0]     tst_addr,
    input  logic              tst_we,
    input  logic [DATA_W-1:0] tst_wdata,
    output logic [DATA_W-1:0] tst_rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage update: the test port wins, but the two never collide.
    always_ff @(posedge clk) begin
        if (tst_we) begin
            mem[tst_addr] <= tst_wdata;
        end else if (ex_we) begin
            mem[ex_addr] <= ex_wdata;
        end
    end

    // Combinational read ports.
    assign ex_rdata  = mem[ex_addr];
    assign tst_rdata = mem[tst_addr];

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        !(ex_we && tst_we));  // R11

endmodule

// File: rtl/nsz_fetch.sv
// Module: nsz_fetch
// One-entry prefetch slot. It takes a new instruction when it is empty or
// when its held instruction is consumed in the same cycle, so execution and
// fetch overlap. Assumes the offered instruction holds steady while it waits.
module nsz_fetch #(
    parameter int AW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      in_op,
    input  logic [AW-1:0]   in_addr,
    output logic            in_ready,
    input  logic            consume,
    output logic            slot_valid,
    output nsz_pkg::nsz_op_e slot_op,
    output logic [AW-1:0]   slot_addr
);
    import nsz_pkg::*;

    assign in_ready = !slot_valid || consume;

    // Slot fill/drain: load on handshake, clear when consumed with no refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid <= 1'b0;
            slot_op    <= OP_SWAP;
            slot_addr  <= '0;
        end else if (in_valid && in_ready) begin
            slot_valid <= 1'b1;
            slot_op    <= nsz_op_e'(in_op);
            slot_addr  <= in_addr;
        end else if (consume) begin
            slot_valid <= 1'b0;
        end
    end

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && !consume) |=> (slot_valid && $stable(slot_op) && $stable(slot_addr)));  // R11

endmodule

// File: rtl/nsz_alu.sv
// Module: nsz_alu
// Combinational datapath for the four operand instructions. It produces the
// memory write, the accumulator write and the zero-skip request. Assumes the
// caller gates the enables with its execute/squash state.
module nsz_alu #(
    parameter int DATA_W = 8,
    localparam int HALF  = DATA_W / 2
) (
    input  nsz_pkg::nsz_op_e  op,
    input  logic [DATA_W-1:0] operand,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              acc_we,
    output logic [DATA_W-1:0] acc_wdata,
    output logic              skip_req
);
    import nsz_pkg::*;

    logic [DATA_W-1:0] swapped;
    logic              is_zero;

    assign swapped = {operand[HALF-1:0], operand[DATA_W-1:HALF]};
    assign is_zero = (operand == '0);

    // Opcode decode into write enables, write data and the skip request.
    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = swapped;
        acc_we    = 1'b0;
        acc_wdata = swapped;
        skip_req  = 1'b0;
        case (op)
            OP_SWAP:  mem_we = 1'b1;
            OP_SWAPA: acc_we = 1'b1;
            OP_SKZ:   skip_req = is_zero;
            OP_MVSKZ: begin
                acc_we    = 1'b1;
                acc_wdata = operand;
                skip_req  = is_zero;
            end
            default:  ;
        endcase
    end

endmodule

// File: rtl/nsz_exec_unit.sv
// Module: nsz_exec_unit (top)
// Execute stage for swap / swap-to-accumulator / skip-if-zero /
// move-and-skip. A held slot executes whenever the test port is idle. A
// taken skip sets a squash flag that turns the next instruction to reach
// execute into a dummy cycle. Assumes a synchronous active-low reset.
// Data memory is never cleared by reset.
module nsz_exec_unit #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    parameter int CNT_W  = 16,
    parameter int STAT_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic [AW-1:0]     in_addr,
    input  logic              tst_we,
    input  logic [AW-1:0]     tst_addr,
    input  logic [DATA_W-1:0] tst_wdata,
    output logic [DATA_W-1:0] tst_rdata,
    output logic [DATA_W-1:0] acc_o,
    output logic [STAT_W-1:0] status_o,
    output logic [CNT_W-1:0]  cyc_cnt_o,
    output logic              retire_o,
    output logic              dummy_o
);
    import nsz_pkg::*;

    logic              slot_valid;
    nsz_op_e           slot_op;
    logic [AW-1:0]     slot_addr;
    logic              consume;
    logic              fire;
    logic              squash_q;
    logic [DATA_W-1:0] operand;
    logic              alu_mem_we;
    logic [DATA_W-1:0] alu_mem_wdata;
    logic              alu_acc_we;
    logic [DATA_W-1:0] alu_acc_wdata;
    logic              alu_skip;
    logic              rf_we;
    logic [DATA_W-1:0] acc_q;
    logic [STAT_W-1:0] status_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              retire_q;
    logic              dummy_q;

    // Slot is consumed when full and the test port is not writing.
    assign consume = slot_valid && !tst_we;
    assign fire    = consume && !squash_q;
    assign rf_we   = fire && alu_mem_we;

    nsz_fetch #(.AW(AW)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_addr    (in_addr),
        .in_ready   (in_ready),
        .consume    (consume),
        .slot_valid (slot_valid),
        .slot_op    (slot_op),
        .slot_addr  (slot_addr)
    );

    nsz_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ex_addr   (slot_addr),
        .ex_rdata  (operand),
        .ex_we     (rf_we),
        .ex_wdata  (alu_mem_wdata),
        .tst_addr  (tst_addr),
        .tst_we    (tst_we),
        .tst_wdata (tst_wdata),
        .tst_rdata (tst_rdata)
    );

    nsz_alu #(.DATA_W(DATA_W)) u_alu (
        .op        (slot_op),
        .operand   (operand),
        .mem_we    (alu_mem_we),
        .mem_wdata (alu_mem_wdata),
        .acc_we    (alu_acc_we),
        .acc_wdata (alu_acc_wdata),
        .skip_req  (alu_skip)
    );

    // Architectural state, squash flag, cycle counter and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            status_q <= '0;
            squash_q <= 1'b0;
            cnt_q    <= '0;
            retire_q <= 1'b0;
            dummy_q  <= 1'b0;
        end else begin
            retire_q <= fire;
            dummy_q  <= consume && squash_q;
            if (consume) begin
                cnt_q    <= cnt_q + 1'b1;
                squash_q <= fire && alu_skip;
            end
            if (fire && alu_acc_we) begin
                acc_q <= alu_acc_wdata;
            end
        end
    end

    assign acc_o     = acc_q;
    assign status_o  = status_q;
    assign cyc_cnt_o = cnt_q;
    assign retire_o  = retire_q;
    assign dummy_o   = dummy_q;

    AST_NO_CHAINED_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
        dummy_q |=> !dummy_q);  // R8
    AST_ACC_HOLD_ON_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
        dummy_q |-> $stable(acc_q));  // R7
    AST_CNT_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_q || dummy_q) |-> ((cnt_q - $past(cnt_q)) == CNT_W'(1)));  // R10
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(retire_q && dummy_q));  // R10
    AST_SWAPA_NO_MEMWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && slot_op == OP_SWAPA) |-> !rf_we);  // R3
    AST_SQUASH_NO_MEMWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && squash_q) |-> !rf_we);  // R7

endmodule

// File: tb/tb_nsz_exec_unit.sv
// Bench for nsz_exec_unit: directed corner cases followed by seeded random
// batches. A bench-side reference model computes the expected results.
module tb_nsz_exec_unit;
    localparam int DW    = 8;
    localparam int DEPTH = 32;
    localparam int AW    = 5;
    localparam int CW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [1:0]    in_op = 2'b00;
    logic [AW-1:0] in_addr = '0;
    logic          tst_we = 1'b0;
    logic [AW-1:0] tst_addr = '0;
    logic [DW-1:0] tst_wdata = '0;
    logic [DW-1:0] tst_rdata;
    logic [DW-1:0] acc_o;
    logic [7:0]    status_o;
    logic [CW-1:0] cyc_cnt_o;
    logic          retire_o;
    logic          dummy_o;

    always #5 clk = ~clk;

    nsz_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_addr(in_addr), .tst_we(tst_we), .tst_addr(tst_addr),
        .tst_wdata(tst_wdata), .tst_rdata(tst_rdata), .acc_o(acc_o),
        .status_o(status_o), .cyc_cnt_o(cyc_cnt_o), .retire_o(retire_o),
        .dummy_o(dummy_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int sends = 0;
    int dummies_seen = 0;
    int retires_seen = 0;
    int dummies_exp = 0;
    logic [DW-1:0] mem_m [DEPTH];
    logic [DW-1:0] acc_m;
    bit            squash_m;
    bit            done = 1'b0;

    // Pulse counters sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dummy_o)  dummies_seen++;
            if (retire_o) retires_seen++;
        end
    end

    function automatic logic [DW-1:0] swapn(input logic [DW-1:0] b);
        return {b[3:0], b[7:4]};
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference model applied in program order.
    task automatic model(input logic [1:0] op, input logic [AW-1:0] a);
        if (squash_m) begin
            squash_m = 1'b0;
            dummies_exp++;
        end else begin
            case (op)
                2'b00: mem_m[a] = swapn(mem_m[a]);
                2'b01: acc_m = swapn(mem_m[a]);
                2'b10: squash_m = (mem_m[a] == 8'h00);
                default: begin
                    acc_m = mem_m[a];
                    squash_m = (mem_m[a] == 8'h00);
                end
            endcase
        end
    endtask

    // Offer one instruction at a negedge; return at the negedge after acceptance.
    task automatic send(input logic [1:0] op, input logic [AW-1:0] a);
        in_valid = 1'b1;
        in_op    = op;
        in_addr  = a;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        model(op, a);
        sends++;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    task automatic tload(input logic [AW-1:0] a, input logic [DW-1:0] d);
        tst_we    = 1'b1;
        tst_addr  = a;
        tst_wdata = d;
        @(negedge clk);
        tst_we = 1'b0;
        mem_m[a] = d;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        tst_addr = a;
        #1;
        d = tst_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        acc_m = '0;
        squash_m = 1'b0;
        sends = 0;
        dummies_seen = 0;
        retires_seen = 0;
        dummies_exp = 0;
    endtask

    task automatic compare_all(input string req);
        logic [DW-1:0] d;
        drain();
        check(req, "acc", acc_o, acc_m);
        for (int i = 0; i < DEPTH; i++) begin
            rd(AW'(i), d);
            check("R12", "mem", d, mem_m[i]);
        end
        check("R7", "dummy count", dummies_seen, dummies_exp);
        check("R10", "cycle count", cyc_cnt_o, sends % (1 << CW));
        check("R10", "retire+dummy", retires_seen + dummies_seen, sends);
        check("R9", "status", status_o, 0);
    endtask

    initial begin
        logic [DW-1:0] d;
        int d0;
        int c0;
        void'($urandom(32'd20240607));
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1", "acc after reset", acc_o, 0);
        check("R1", "status after reset", status_o, 0);
        check("R1", "count after reset", cyc_cnt_o, 0);
        check("R1", "ready after reset", in_ready, 1);
        check("R1", "dummy after reset", dummy_o, 0);
        for (int i = 0; i < DEPTH; i++) tload(AW'(i), DW'(i * 37 + 5));
        tload(5'd3, 8'hA5);
        tload(5'd4, 8'h00);
        tload(5'd6, 8'h3C);
        tload(5'd7, 8'h00);
        do_reset();
        rd(5'd3, d);
        check("R1", "memory kept over reset", d, 8'hA5);
        rd(5'd12, d);
        check("R12", "test readback", d, mem_m[12]);

        // R2 in-place swap
        send(2'b00, 5'd3); drain();
        rd(5'd3, d);
        check("R2", "swapped byte", d, 8'h5A);
        check("R2", "acc untouched", acc_o, 8'h00);

        // R3 swap into accumulator
        send(2'b01, 5'd3); drain();
        check("R3", "acc", acc_o, 8'hA5);
        rd(5'd3, d);
        check("R3", "memory unchanged", d, 8'h5A);

        // R4 / R7 taken skip: next instruction becomes a dummy
        d0 = dummies_seen; c0 = int'(cyc_cnt_o);
        send(2'b10, 5'd4); send(2'b01, 5'd6); drain();
        check("R4", "one dummy", dummies_seen - d0, 1);
        check("R7", "acc kept over dummy", acc_o, 8'hA5);
        check("R4", "two cycles", int'(cyc_cnt_o) - c0, 2);

        // R5 not-taken skip costs one cycle
        d0 = dummies_seen; c0 = int'(cyc_cnt_o);
        send(2'b10, 5'd6); drain();
        check("R5", "one cycle", int'(cyc_cnt_o) - c0, 1);
        send(2'b01, 5'd6); drain();
        check("R5", "no dummy", dummies_seen - d0, 0);
        check("R5", "next executes", acc_o, 8'hC3);

        // R6 move-and-skip, zero and nonzero
        d0 = dummies_seen;
        send(2'b11, 5'd7); send(2'b01, 5'd3); drain();
        check("R6", "acc copy of zero", acc_o, 8'h00);
        check("R6", "zero skips", dummies_seen - d0, 1);
        d0 = dummies_seen;
        send(2'b11, 5'd6); drain();
        check("R6", "acc copy", acc_o, 8'h3C);
        send(2'b01, 5'd3); drain();
        check("R6", "nonzero no skip", dummies_seen - d0, 0);
        check("R6", "next executes", acc_o, 8'hA5);

        // R8 squashed skip does not skip again
        d0 = dummies_seen;
        send(2'b10, 5'd4); send(2'b10, 5'd4); send(2'b01, 5'd6); drain();
        check("R8", "single dummy", dummies_seen - d0, 1);
        check("R8", "third executes", acc_o, 8'hC3);

        // R11 test write stalls a full slot
        send(2'b00, 5'd5);
        c0 = int'(cyc_cnt_o);
        tst_we = 1'b1; tst_addr = 5'd20; tst_wdata = 8'h33;
        #1;
        check("R11", "ready low while stalled", in_ready, 0);
        @(negedge clk);
        tst_we = 1'b0;
        mem_m[20] = 8'h33;
        check("R11", "no execute during stall", int'(cyc_cnt_o) - c0, 0);
        compare_all("R11");

        // Random batches
        for (int b = 0; b < 40; b++) begin
            for (int k = 0; k < 4; k++) begin
                tload(AW'($urandom_range(0, 7)), ($urandom_range(0, 2) == 0) ? 8'h00 : DW'($urandom));
            end
            for (int k = 0; k < 20; k++) begin
                send(2'($urandom), AW'($urandom_range(0, 7)));
            end
            compare_all("R6");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule